// File: doc/BRIEF.md
# Stereo I2S Serial Audio Port

This block moves 16-bit stereo audio between a parallel sample interface and a three-wire I2S serial line. Each channel word goes out MSB first. The first bit follows the word-select change by one bit clock. Transmit bits change on the falling edge of the bit clock, and receive bits are taken on the rising edge. The left channel occupies the low phase of word select and the right channel the high phase. Bit positions after the sixteenth in a channel slot carry zeros on transmit and are discarded on receive.

As bit-clock master, the port makes the bit clock and word select itself. It toggles the bit clock on each pulse of a tick input that an external divider supplies. Each channel slot is 16 bit clocks long, or 25 when the long frame is selected, so a stereo frame is 32 or 50 bit clocks. As slave, it takes the bit clock and word select from the line through two-flop synchronisers and works from their edges. In slave mode any slot length of at least 16 works, for example 32 bits per channel.

All logic runs on one system clock. A single-pair holding register feeds the transmitter through a valid/ready handshake. Received pairs leave on a one-cycle strobe.

Top module: `i2s_port`

## Requirements
- R1: `clk_oe` is 1 when `master_en` is 1 and 0 otherwise. After reset, `bclk_o` is 0, `ws_o` is 1, `sdo` is 0, `tx_ready` is 1, and `rx_valid` and `underrun` are 0.
- R2: In master mode, `bclk_o` toggles once for each `bclk_tick` pulse. `ws_o` changes only together with a falling edge of `bclk_o`, once every 16 bit clocks when `frame50` is 0 and once every 25 when `frame50` is 1.
- R3: `sdo` changes only at falling bit-clock edges. Each 16-bit word is sent MSB first, and its MSB is driven at the first falling edge after the rising edge that sees the new word-select level.
- R4: The left word is carried while word select is 0 and the right word while it is 1. This holds for both transmit and receive.
- R5: After the sixteenth bit of a slot, `sdo` stays 0 for the remaining bit clocks of that slot.
- R6: `sdi` is sampled on rising bit-clock edges as 16-bit MSB-first words. After the right word's LSB, `rx_valid` is 1 for exactly one system clock, with `rx_left` and `rx_right` holding that frame's words.
- R7: Received bits beyond the sixteenth in a slot do not alter the delivered words.
- R8: The transmit side holds one pair, and `tx_ready` is 1 while that holder is empty. A pair is taken when `tx_valid` and `tx_ready` are both 1. Pairs go out in order, one per frame, each taken at the start of a left slot.
- R9: If the holder is empty at the start of a left slot, the previous pair is sent again and `underrun` becomes 1. It stays 1 until `underrun_clr` is 1. A new underrun in the same cycle wins over the clear.
- R10: In slave mode, `bclk_i` and `ws_i` pass through two-stage synchronisers. The port handles bit clocks of up to one eighth of the system clock and slots of 32 bits per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = bit-clock master, 0 = slave |
| frame50 | input | 1 | Master frame length: 0 = 32 bit clocks, 1 = 50 bit clocks |
| bclk_tick | input | 1 | Divider pulse; each pulse toggles the master bit clock |
| bclk_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| sdi | input | 1 | Serial data in |
| bclk_o | output | 1 | Master bit clock |
| ws_o | output | 1 | Master word select |
| clk_oe | output | 1 | Output enable for `bclk_o` and `ws_o` |
| sdo | output | 1 | Serial data out |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit holder empty |
| tx_left | input | 16 | Left transmit word |
| tx_right | input | 16 | Right transmit word |
| rx_valid | output | 1 | One-cycle strobe for a received pair |
| rx_left | output | 16 | Received left word |
| rx_right | output | 16 | Received right word |
| underrun | output | 1 | Sticky transmit underrun flag |
| underrun_clr | input | 1 | Clears `underrun` |

## Verification
The hardest situation to reach from the ports is the long-frame and slave cases. Here the trailing bit clocks of a slot must carry zeros outward and have no effect inward, while words stay aligned across many frames. To get there, the bench runs an independent line-side transmitter that fills every position past the sixteenth with ones, and a line-side decoder that checks each of those positions on `sdo`. Underrun is provoked by withholding pairs after a short burst. The repeated pair, the flag and its clear are then checked while the bit clock is stopped, so no new slot start can race the clear.

// File: rtl/i2s_pkg.sv
package i2s_pkg;

    // Bit-clock events seen in the system-clock domain during one cycle.
    // ws is the word-select level valid after this cycle's edge.
    typedef struct packed {
        logic rise;
        logic fall;
        logic ws;
    } bit_evt_t;

endpackage

// File: rtl/i2s_master_clk.sv
module i2s_master_clk
    import i2s_pkg::*;
#(
    parameter int unsigned SHORT_SLOT = 16,
    parameter int unsigned LONG_SLOT  = 25
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     tick,
    input  logic     long_frame,
    output logic     bclk,
    output logic     ws,
    output bit_evt_t evt
);
    localparam int unsigned CNT_W = $clog2(LONG_SLOT + 1);

    typedef struct packed {
        logic             bclk;
        logic             ws;
        logic [CNT_W-1:0] cnt;
    } mclk_st_t;

    mclk_st_t         q, d;
    logic [CNT_W-1:0] last;
    logic             rise, fall;

    always_comb begin
        last = long_frame ? CNT_W'(LONG_SLOT - 1) : CNT_W'(SHORT_SLOT - 1);
        d    = q;
        rise = 1'b0;
        fall = 1'b0;
        if (en && tick) begin
            d.bclk = ~q.bclk;
            if (q.bclk) begin
                fall = 1'b1;
                // slot boundary: counter wraps, word select flips with this falling edge
                if (q.cnt >= last) begin
                    d.cnt = '0;
                    d.ws  = ~q.ws;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                rise = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{bclk: 1'b0, ws: 1'b1, cnt: {CNT_W{1'b1}}};
        end else begin
            q <= d;
        end
    end

    assign bclk = q.bclk;
    assign ws   = q.ws;
    assign evt  = '{rise: rise, fall: fall, ws: d.ws};

    // R2
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ws != $past(q.ws)) |-> $past(fall));

    // R2
    bclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bclk != $past(q.bclk)) |-> $past(en && tick));

endmodule

// File: rtl/i2s_slave_sync.sv
module i2s_slave_sync
    import i2s_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bclk_in,
    input  logic     ws_in,
    output bit_evt_t evt
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ws;
        logic              sck_prev;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[STAGES-2:0], bclk_in};
        d.ws       = {q.ws[STAGES-2:0], ws_in};
        d.sck_prev = q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign evt = '{rise: q.sck[STAGES-1] & ~q.sck_prev,
                   fall: ~q.sck[STAGES-1] & q.sck_prev,
                   ws:   q.ws[STAGES-1]};

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bit_evt_t     evt,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_left,
    input  logic [W-1:0] tx_right,
    input  logic         underrun_clr,
    output logic         tx_ready,
    output logic         sdo,
    output logic         underrun
);
    localparam int unsigned LEFT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]      buf_l;
        logic [W-1:0]      buf_r;
        logic              full;
        logic [W-1:0]      act_l;
        logic [W-1:0]      act_r;
        logic [W-1:0]      shreg;
        logic [LEFT_W-1:0] left;
        logic              pend;
        logic              ws_r;
        logic              sdo;
        logic              under;
    } tx_st_t;

    tx_st_t       q, d;
    logic [W-1:0] word, nl, nr;

    always_comb begin
        d    = q;
        word = '0;
        nl   = q.act_l;
        nr   = q.act_r;
        if (underrun_clr) begin
            d.under = 1'b0;
        end
        if (tx_valid && !q.full) begin
            d.buf_l = tx_left;
            d.buf_r = tx_right;
            d.full  = 1'b1;
        end
        // word select is taken on the rising edge; a change arms a word load
        if (evt.rise) begin
            d.ws_r = evt.ws;
            if (evt.ws != q.ws_r) begin
                d.pend = 1'b1;
            end
        end
        if (evt.fall) begin
            if (q.pend) begin
                if (!q.ws_r) begin
                    if (q.full) begin
                        nl     = q.buf_l;
                        nr     = q.buf_r;
                        d.full = 1'b0;
                    end else begin
                        d.under = 1'b1;
                    end
                    d.act_l = nl;
                    d.act_r = nr;
                    word    = nl;
                end else begin
                    word = q.act_r;
                end
                d.sdo   = word[W-1];
                d.shreg = {word[W-2:0], 1'b0};
                d.left  = LEFT_W'(W - 1);
                d.pend  = 1'b0;
            end else if (q.left != '0) begin
                d.sdo   = q.shreg[W-1];
                d.shreg = {q.shreg[W-2:0], 1'b0};
                d.left  = q.left - 1'b1;
            end else begin
                d.sdo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ws_r <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_ready = ~q.full;
    assign sdo      = q.sdo;
    assign underrun = q.under;

    // R3
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sdo != $past(q.sdo)) |-> $past(evt.fall));

    // R5
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.fall && !q.pend && (q.left == '0)) |=> !sdo);

    // R9
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.under && !$past(q.under)) |-> $past(evt.fall && q.pend && !q.ws_r && !q.full));

    // R8
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
    import i2s_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bit_evt_t     evt,
    input  logic         sdi,
    output logic         rx_valid,
    output logic [W-1:0] rx_left,
    output logic [W-1:0] rx_right
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             ws_r;
        logic             ch;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
        logic [W-1:0]     left_w;
        logic             got_l;
        logic [W-1:0]     out_l;
        logic [W-1:0]     out_r;
        logic             vld;
    } rx_st_t;

    rx_st_t       q, d;
    logic [W-1:0] nsh;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        nsh   = {q.sh[W-2:0], sdi};
        if (evt.rise) begin
            // bits past the word length are dropped: cnt saturates at W
            if (q.cnt < CNT_W'(W)) begin
                d.sh  = nsh;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(W - 1)) begin
                    if (!q.ch) begin
                        d.left_w = nsh;
                        d.got_l  = 1'b1;
                    end else if (q.got_l) begin
                        d.out_l = q.left_w;
                        d.out_r = nsh;
                        d.vld   = 1'b1;
                        d.got_l = 1'b0;
                    end
                end
            end
            d.ws_r = evt.ws;
            if (evt.ws != q.ws_r) begin
                d.cnt = '0;
                d.ch  = evt.ws;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ws_r <= 1'b1;
            q.cnt  <= CNT_W'(W);
        end else begin
            q <= d;
        end
    end

    assign rx_valid = q.vld;
    assign rx_left  = q.out_l;
    assign rx_right = q.out_r;

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    rx_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(evt.rise));

endmodule

// File: rtl/i2s_port.sv
module i2s_port
    import i2s_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned SHORT_SLOT  = 16,
    parameter int unsigned LONG_SLOT   = 25,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic                frame50,
    input  logic                bclk_tick,
    input  logic                bclk_i,
    input  logic                ws_i,
    input  logic                sdi,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                clk_oe,
    output logic                sdo,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                underrun,
    input  logic                underrun_clr
);
    bit_evt_t m_evt, s_evt, evt;

    i2s_master_clk #(.SHORT_SLOT(SHORT_SLOT), .LONG_SLOT(LONG_SLOT)) u_mclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (master_en),
        .tick       (bclk_tick),
        .long_frame (frame50),
        .bclk       (bclk_o),
        .ws         (ws_o),
        .evt        (m_evt)
    );

    i2s_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_in (bclk_i),
        .ws_in   (ws_i),
        .evt     (s_evt)
    );

    assign evt    = master_en ? m_evt : s_evt;
    assign clk_oe = master_en;

    i2s_tx #(.W(SAMPLE_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .tx_valid     (tx_valid),
        .tx_left      (tx_left),
        .tx_right     (tx_right),
        .underrun_clr (underrun_clr),
        .tx_ready     (tx_ready),
        .sdo          (sdo),
        .underrun     (underrun)
    );

    i2s_rx #(.W(SAMPLE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .sdi      (sdi),
        .rx_valid (rx_valid),
        .rx_left  (rx_left),
        .rx_right (rx_right)
    );

endmodule

// File: tb/i2s_port_tb_top.sv
module i2s_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1, frame50 = 1'b0, bclk_tick = 1'b0;
    logic        sck_tb = 1'b0, ws_tb = 1'b1, sdi = 1'b0;
    logic        bclk_o, ws_o, clk_oe, sdo, tx_ready, rx_valid, underrun;
    logic        tx_valid = 1'b0, underrun_clr = 1'b0;
    logic [15:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

    always #2 clk = ~clk;

    i2s_port dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .frame50(frame50),
        .bclk_tick(bclk_tick), .bclk_i(sck_tb), .ws_i(ws_tb), .sdi(sdi),
        .bclk_o(bclk_o), .ws_o(ws_o), .clk_oe(clk_oe), .sdo(sdo),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
        .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right),
        .underrun(underrun), .underrun_clr(underrun_clr)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic run = 1'b0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [31:0] last_tx = '0;
    int send_req = 0, send_done = 0, tx_pairs = 0, rx_pairs = 0, seq = 0;
    int div = 0, sdiv = 0, scnt = 31;
    logic prev_clk = 1'b0;
    int dcnt = 16, rcnt = 0;
    logic dws = 1'b1, dch = 1'b0, dact = 1'b0, dseen = 1'b0, dgot = 1'b0;
    logic [15:0] dsh = '0, dl = '0;
    int bidx = 16;
    logic bws = 1'b1;
    logic [15:0] bw = '0, bpr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pair(input int s);
        logic [15:0] l, r;
        l = 16'(s * 16'h2F1B) ^ 16'h8001;
        r = ~l ^ 16'(s << 3);
        return {l, r};
    endfunction

    task automatic mon();
        logic line_clk, line_ws, rise, fall;
        logic [31:0] p, e;
        if (run && master_en) begin
            div = (div + 1) % 4;
            bclk_tick = (div == 0);
        end else begin
            bclk_tick = 1'b0;
        end
        if (run && !master_en) begin
            sdiv++;
            if (sdiv == 8) begin
                sdiv = 0;
                if (sck_tb) begin
                    scnt++;
                    if (scnt == 32) begin scnt = 0; ws_tb = ~ws_tb; end
                end
                sck_tb = ~sck_tb;
            end
        end
        line_clk = master_en ? bclk_o : sck_tb;
        line_ws  = master_en ? ws_o : ws_tb;
        rise = line_clk & ~prev_clk;
        fall = ~line_clk & prev_clk;
        prev_clk = line_clk;

        // driver side of the transmit scoreboard (R8)
        if (tx_valid) begin
            chk(tx_ready == 1'b0, "R8", "ready after accept", 32'(tx_ready), 0);
            tx_valid = 1'b0;
            send_done++;
        end else if (send_done < send_req && tx_ready) begin
            p = mk_pair(seq + 100);
            seq++;
            tx_left = p[31:16];
            tx_right = p[15:0];
            tx_valid = 1'b1;
            txq.push_back(p);
        end

        // line-side transmitter feeding sdi, trailing bits forced to 1 (R7)
        if (fall) begin
            if (bidx < 16) begin sdi = bw[15 - bidx]; bidx++; end
            else sdi = 1'b1;
            if (line_ws != bws) begin
                bws = line_ws;
                bidx = 0;
                if (!line_ws) begin
                    p = mk_pair(seq + 7000);
                    seq++;
                    rxq.push_back(p);
                    bw = p[31:16];
                    bpr = p[15:0];
                end else begin
                    bw = bpr;
                end
            end
        end

        // line-side decoder of sdo (monitor side of the transmit scoreboard)
        if (rise) begin
            rcnt++;
            if (dcnt < 16) begin
                dsh = {dsh[14:0], sdo};
                dcnt++;
                if (dcnt == 16) begin
                    if (!dch) begin
                        dl = dsh; dgot = 1'b1;
                    end else if (dgot) begin
                        dgot = 1'b0;
                        if (txq.size() > 0) begin
                            e = txq.pop_front();
                            last_tx = e;
                            chk({dl, dsh} == e, "R3 R4", "tx pair", {dl, dsh}, e);
                        end else begin
                            chk({dl, dsh} == last_tx, "R9", "repeated pair", {dl, dsh}, last_tx);
                        end
                        tx_pairs++;
                    end
                end
            end else if (dact) begin
                chk(sdo == 1'b0, "R5", "trailing bit", 32'(sdo), 0);
            end
            if (line_ws != dws) begin
                if (master_en && dseen)
                    chk(rcnt == (frame50 ? 25 : 16), "R2", "slot length", rcnt, frame50 ? 25 : 16);
                dws = line_ws; dch = line_ws; dcnt = 0; dact = 1'b1; dseen = 1'b1; rcnt = 0;
            end
        end

        // receive scoreboard
        if (rx_valid) begin
            if (rxq.size() > 0) begin
                e = rxq.pop_front();
                chk({rx_left, rx_right} == e, "R6 R7", "rx pair", {rx_left, rx_right}, e);
            end else begin
                chk(1'b0, "R6", "unexpected rx pair", {rx_left, rx_right}, 0);
            end
            rx_pairs++;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
        mon();
    endtask

    task automatic do_reset(input logic m, input logic f50);
        rst_n = 1'b0; run = 1'b0; master_en = m; frame50 = f50;
        tx_valid = 1'b0; underrun_clr = 1'b0; sdi = 1'b0;
        send_req = 0; send_done = 0; tx_pairs = 0; rx_pairs = 0;
        txq.delete(); rxq.delete(); last_tx = '0;
        div = 0; sdiv = 0; scnt = 31; sck_tb = 1'b0; ws_tb = 1'b1; prev_clk = 1'b0;
        dcnt = 16; rcnt = 0; dws = 1'b1; dch = 1'b0; dact = 1'b0; dseen = 1'b0; dgot = 1'b0;
        bidx = 16; bws = 1'b1;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state and direction control
        chk(clk_oe == m, "R1", "clk_oe", 32'(clk_oe), 32'(m));
        chk(bclk_o == 1'b0 && ws_o == 1'b1 && sdo == 1'b0, "R1", "line reset",
            {29'd0, bclk_o, ws_o, sdo}, 32'b010);
        chk(tx_ready && !rx_valid && !underrun, "R1", "flags reset",
            {29'd0, tx_ready, rx_valid, underrun}, 32'b100);
    endtask

    task automatic run_seg(input logic m, input logic f50, input int npairs);
        do_reset(m, f50);
        send_req = npairs;
        repeat (4) step();
        run = 1'b1;
        for (int i = 0; i < 60000 && tx_pairs < npairs; i++) step();
        chk(tx_pairs >= npairs, "R8", "pairs sent", tx_pairs, npairs);
        chk(rx_pairs >= npairs - 2, "R6", "pairs received", rx_pairs, npairs - 2);
    endtask

    initial begin
        // master, 32-bit frame, then starve the transmitter (R9)
        run_seg(1'b1, 1'b0, 6);
        for (int i = 0; i < 3000 && !underrun; i++) step();
        chk(underrun == 1'b1, "R9", "underrun set", 32'(underrun), 1);
        chk(tx_ready == 1'b1, "R8", "holder empty", 32'(tx_ready), 1);
        for (int i = 0; i < 3000 && tx_pairs < 8; i++) step();
        run = 1'b0;
        repeat (3) step();
        chk(underrun == 1'b1, "R9", "underrun sticky", 32'(underrun), 1);
        underrun_clr = 1'b1;
        step();
        underrun_clr = 1'b0;
        step();
        chk(underrun == 1'b0, "R9", "underrun cleared", 32'(underrun), 0);

        // master, 50-bit frame: trailing zeros and ignored trailing input (R5, R7)
        run_seg(1'b1, 1'b1, 6);

        // slave, 64-bit frame from external clock at 1/16 system clock (R10)
        run_seg(1'b0, 1'b0, 5);
        chk(clk_oe == 1'b0, "R10", "slave oe", 32'(clk_oe), 0);

        finish_run();
    end
endmodule